// File: doc/BRIEF.md
# Hidden IDE Channel Timing Configuration Front End

This block sits between a host I/O port and a legacy IDE drive channel. Normally every host access to the eight command-block offsets goes straight through to the drive. The channel's timing registers have no address space of their own. They are reached through a key sequence on the same offsets: two 16-bit reads of offset 1, then an 8-bit write of 0x03 to offset 2. That sequence opens a configuration window.

While the window is open, byte writes are captured by the block and do not reach the drive:

- Offset 0 loads the read-cycle timing of the selected device.
- Offset 1 loads the write-cycle timing of the selected device.
- Offset 3 is the control register.
- Offset 6 either selects the device or sets the address-setup value.

A byte write of 0x83 to offset 2 closes the window. Each timing byte holds a data-active count and a recovery count, one per nibble. The block only stores and presents these bytes; it does not generate drive cycles.

A board strap reports the bus clock speed. Software reads the strap by writing 0xFF to offset 5 and then doing a 16-bit read of offset 5. Until the control register holds the commit key 0x85, the timing outputs show the slowest-mode defaults for the strapped clock. Once the commit key is written, the timing outputs show the programmed values.

Top module: `ide_cfg_trapdoor`

## Requirements
- R1: After reset the window is closed and override is off. The timing outputs show the strap defaults: 0x6B for both timings and setup 3 when clk_strap is 0, and 0x58 with setup 2 when clk_strap is 1. The stored registers hold 0x6B and setup 3.
- R2: A 16-bit read of offset 1, another 16-bit read of offset 1, then a byte write of 0x03 to offset 2 opens the window after that write. Extra 16-bit reads of offset 1 before the write are allowed. All three key accesses are forwarded to the drive.
- R3: Any access that breaks the key sequence returns the detector to its idle state, and the window stays closed. Breaking accesses include a byte read of offset 1, an access to another offset, and a write of any value other than 0x03 to offset 2.
- R4: While the window is open, no host write and no host read reaches the drive. Reads return 0x0000. A 16-bit write changes no register.
- R5: While open, a byte write to offset 0 sets the read timing of the selected device. A byte write to offset 1 sets that device's write timing. The other device keeps its values.
- R6: While open, a byte write to offset 6 whose upper nibble is 0 selects the device given by bit 0. If the upper nibble is non-zero, that nibble becomes the shared address-setup value and the device selection is unchanged.
- R7: While open, a byte write of 0x85 to offset 3 turns override on, and the timing and setup outputs then show the programmed values. Any other value written to offset 3 turns override off.
- R8: While open, a byte write of 0x83 to offset 2 is absorbed and closes the window; later accesses are forwarded again. Any other value written to offset 2 is absorbed and the window stays open.
- R9: While closed, a byte write of 0xFF to offset 5 arms the strap probe. If the next access is a 16-bit read of offset 5, it returns the registered strap in bit 0 with all other bits 0 and is not forwarded. Any other access in between disarms the probe.
- R10: While closed, outside a strap probe, reads return the drive's data and all addresses, widths and write data pass through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 3 | Host command-block offset |
| host_rd | input | 1 | Host read strobe, one cycle per access |
| host_wr | input | 1 | Host write strobe, one cycle per access |
| host_word | input | 1 | 1 for 16-bit access, 0 for byte |
| host_wdata | input | 16 | Host write data, byte in bits 7:0 |
| host_rdata | output | 16 | Read data returned to host |
| drv_addr | output | 3 | Offset forwarded to drive |
| drv_rd | output | 1 | Forwarded read strobe |
| drv_wr | output | 1 | Forwarded write strobe |
| drv_word | output | 1 | Forwarded access width |
| drv_wdata | output | 16 | Forwarded write data |
| drv_rdata | input | 16 | Drive read data |
| clk_strap | input | 1 | Board bus-clock strap, 1 = fast |
| cfg_open | output | 1 | Configuration window open |
| timing_override | output | 1 | Programmed timings in force |
| strap_clk | output | 1 | Registered strap value |
| dev_sel | output | 1 | Currently selected device |
| addr_setup | output | 4 | Effective address-setup count |
| dev_rd_tim | output | 16 | Effective read timings, device 0 in bits 7:0 |
| dev_wr_tim | output | 16 | Effective write timings, device 0 in bits 7:0 |

## Verification
A detector stuck in the wrong state shows up on the first access after it. A window that opens wrongly makes the next host write disappear from drv_wr in that same cycle. A window that fails to open lets the next programming write appear on the drive bus. A register written to the wrong device or wrong field only becomes visible once override is on; for that reason every programming test commits with 0x85 and then compares every timing output one cycle later. A wrong strap-probe state shows up on the following 16-bit read of offset 5, in the same cycle, as either drive data or a missing drv_rd.

// File: rtl/ide_cfg_pkg.sv
package ide_cfg_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ONE  = 2'd1,
    SEQ_TWO  = 2'd2,
    SEQ_OPEN = 2'd3
  } seq_state_e;

  localparam logic [2:0] OFS_RDTIM = 3'd0;
  localparam logic [2:0] OFS_WRTIM = 3'd1;
  localparam logic [2:0] OFS_KEY   = 3'd2;
  localparam logic [2:0] OFS_CTRL  = 3'd3;
  localparam logic [2:0] OFS_STRAP = 3'd5;
  localparam logic [2:0] OFS_MISC  = 3'd6;

  localparam logic [7:0] KEY_OPEN   = 8'h03;
  localparam logic [7:0] KEY_CLOSE  = 8'h83;
  localparam logic [7:0] KEY_COMMIT = 8'h85;
  localparam logic [7:0] KEY_PROBE  = 8'hFF;

  // slowest-mode cycle byte: active count in upper nibble, recovery in lower
  function automatic logic [7:0] pio0_cycle(input logic fast);
    return fast ? 8'h58 : 8'h6B;
  endfunction

  function automatic logic [3:0] pio0_setup(input logic fast);
    return fast ? 4'h2 : 4'h3;
  endfunction

endpackage

// File: rtl/ide_unlock_seq.sv
module ide_unlock_seq
  import ide_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_rd,
  input  logic       acc_wr,
  input  logic       acc_word,
  input  logic [2:0] acc_addr,
  input  logic [7:0] acc_byte,
  output logic       open_o
);

  seq_state_e state_q, state_d;
  logic       any_acc, key_read, open_write, close_write;

  assign any_acc     = acc_rd | acc_wr;
  assign key_read    = acc_rd & acc_word & (acc_addr == OFS_WRTIM);
  assign open_write  = acc_wr & ~acc_word & (acc_addr == OFS_KEY) & (acc_byte == KEY_OPEN);
  assign close_write = acc_wr & ~acc_word & (acc_addr == OFS_KEY) & (acc_byte == KEY_CLOSE);

  always_comb begin
    state_d = state_q;
    if (any_acc) begin
      unique case (state_q)
        SEQ_IDLE: state_d = key_read ? SEQ_ONE : SEQ_IDLE;
        SEQ_ONE:  state_d = key_read ? SEQ_TWO : SEQ_IDLE;
        SEQ_TWO: begin
          if (key_read)        state_d = SEQ_TWO;
          else if (open_write) state_d = SEQ_OPEN;
          else                 state_d = SEQ_IDLE;
        end
        SEQ_OPEN: state_d = close_write ? SEQ_IDLE : SEQ_OPEN;
        default:  state_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  assign open_o = (state_q == SEQ_OPEN);

endmodule

// File: rtl/ide_strap_probe.sv
module ide_strap_probe
  import ide_cfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       strap_in,
  input  logic       locked,
  input  logic       acc_rd,
  input  logic       acc_wr,
  input  logic       acc_word,
  input  logic [2:0] acc_addr,
  input  logic [7:0] acc_byte,
  output logic       strap_o,
  output logic       hit_o
);

  logic strap_q;
  logic armed_q, armed_d;
  logic any_acc;

  assign any_acc = acc_rd | acc_wr;
  assign hit_o   = armed_q & locked & acc_rd & acc_word & (acc_addr == OFS_STRAP);

  always_comb begin
    armed_d = armed_q;
    if (any_acc)
      armed_d = locked & acc_wr & ~acc_word & (acc_addr == OFS_STRAP) & (acc_byte == KEY_PROBE);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strap_q <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      strap_q <= strap_in;
      armed_q <= armed_d;
    end
  end

  assign strap_o = strap_q;

endmodule

// File: rtl/ide_timing_bank.sv
module ide_timing_bank
  import ide_cfg_pkg::*;
#(
  parameter int NUM_DEV = 2,
  parameter int TW      = 8,
  parameter int SW      = 4,
  localparam int DEV_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_stb,
  input  logic [2:0]            wr_addr,
  input  logic [7:0]            wr_byte,
  input  logic                  fast_clk,
  output logic [NUM_DEV*TW-1:0] rd_flat,
  output logic [NUM_DEV*TW-1:0] wr_flat,
  output logic [SW-1:0]         setup_o,
  output logic                  override_o,
  output logic [DEV_W-1:0]      dev_sel_o
);

  logic [DEV_W-1:0] sel_q, sel_d;
  logic [SW-1:0]    setup_q, setup_d;
  logic [7:0]       ctrl_q, ctrl_d;
  logic             misc_wr, is_select;

  assign misc_wr   = wr_stb & (wr_addr == OFS_MISC);
  assign is_select = (wr_byte[7:4] == 4'h0);

  always_comb begin
    sel_d   = sel_q;
    setup_d = setup_q;
    ctrl_d  = ctrl_q;
    if (misc_wr && is_select)  sel_d   = wr_byte[DEV_W-1:0];
    if (misc_wr && !is_select) setup_d = wr_byte[4 +: SW];
    if (wr_stb && wr_addr == OFS_CTRL) ctrl_d = wr_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= '0;
      setup_q <= SW'(pio0_setup(1'b0));
      ctrl_q  <= 8'h00;
    end else begin
      sel_q   <= sel_d;
      setup_q <= setup_d;
      ctrl_q  <= ctrl_d;
    end
  end

  assign override_o = (ctrl_q == KEY_COMMIT);
  assign setup_o    = override_o ? setup_q : SW'(pio0_setup(fast_clk));
  assign dev_sel_o  = sel_q;

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_dev
    logic [TW-1:0] rd_q, wr_q;
    logic          mine, ld_rd, ld_wr;

    assign mine  = (sel_q == DEV_W'(d));
    assign ld_rd = wr_stb & mine & (wr_addr == OFS_RDTIM);
    assign ld_wr = wr_stb & mine & (wr_addr == OFS_WRTIM);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rd_q <= TW'(pio0_cycle(1'b0));
        wr_q <= TW'(pio0_cycle(1'b0));
      end else begin
        if (ld_rd) rd_q <= TW'(wr_byte);
        if (ld_wr) wr_q <= TW'(wr_byte);
      end
    end

    assign rd_flat[d*TW +: TW] = override_o ? rd_q : TW'(pio0_cycle(fast_clk));
    assign wr_flat[d*TW +: TW] = override_o ? wr_q : TW'(pio0_cycle(fast_clk));
  end

endmodule

// File: rtl/ide_cfg_trapdoor.sv
module ide_cfg_trapdoor
  import ide_cfg_pkg::*;
#(
  parameter int NUM_DEV = 2,
  parameter int TW      = 8,
  parameter int SW      = 4,
  parameter int DW      = 16,
  localparam int DEV_W  = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2:0]            host_addr,
  input  logic                  host_rd,
  input  logic                  host_wr,
  input  logic                  host_word,
  input  logic [DW-1:0]         host_wdata,
  output logic [DW-1:0]         host_rdata,
  output logic [2:0]            drv_addr,
  output logic                  drv_rd,
  output logic                  drv_wr,
  output logic                  drv_word,
  output logic [DW-1:0]         drv_wdata,
  input  logic [DW-1:0]         drv_rdata,
  input  logic                  clk_strap,
  output logic                  cfg_open,
  output logic                  timing_override,
  output logic                  strap_clk,
  output logic [DEV_W-1:0]      dev_sel,
  output logic [SW-1:0]         addr_setup,
  output logic [NUM_DEV*TW-1:0] dev_rd_tim,
  output logic [NUM_DEV*TW-1:0] dev_wr_tim
);

  // reset asserts at once, releases two edges after rst_n rises
  logic [1:0] rst_pipe;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  logic       open_w, probe_hit;
  logic [7:0] host_byte;

  assign host_byte = host_wdata[7:0];

  ide_unlock_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .acc_rd   (host_rd),
    .acc_wr   (host_wr),
    .acc_word (host_word),
    .acc_addr (host_addr),
    .acc_byte (host_byte),
    .open_o   (open_w)
  );

  ide_strap_probe u_probe (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .strap_in (clk_strap),
    .locked   (~open_w),
    .acc_rd   (host_rd),
    .acc_wr   (host_wr),
    .acc_word (host_word),
    .acc_addr (host_addr),
    .acc_byte (host_byte),
    .strap_o  (strap_clk),
    .hit_o    (probe_hit)
  );

  ide_timing_bank #(
    .NUM_DEV (NUM_DEV),
    .TW      (TW),
    .SW      (SW)
  ) u_bank (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .wr_stb     (open_w & host_wr & ~host_word),
    .wr_addr    (host_addr),
    .wr_byte    (host_byte),
    .fast_clk   (strap_clk),
    .rd_flat    (dev_rd_tim),
    .wr_flat    (dev_wr_tim),
    .setup_o    (addr_setup),
    .override_o (timing_override),
    .dev_sel_o  (dev_sel)
  );

  assign drv_addr  = host_addr;
  assign drv_word  = host_word;
  assign drv_wdata = host_wdata;
  assign drv_rd    = host_rd & ~open_w & ~probe_hit;
  assign drv_wr    = host_wr & ~open_w;
  assign cfg_open  = open_w;

  always_comb begin
    if (probe_hit)   host_rdata = DW'(strap_clk);
    else if (open_w) host_rdata = '0;
    else             host_rdata = drv_rdata;
  end

endmodule

// File: rtl/ide_cfg_trapdoor_chk.sv
module ide_cfg_trapdoor_chk #(
  parameter int NUM_DEV = 2,
  parameter int TW      = 8,
  parameter int DW      = 16
)(
  input logic                  clk,
  input logic                  rst_n,
  input logic [2:0]            host_addr,
  input logic                  host_rd,
  input logic                  host_wr,
  input logic                  host_word,
  input logic [DW-1:0]         host_wdata,
  input logic [DW-1:0]         host_rdata,
  input logic                  drv_rd,
  input logic                  drv_wr,
  input logic                  cfg_open,
  input logic                  strap_clk,
  input logic [NUM_DEV*TW-1:0] dev_rd_tim,
  input logic [NUM_DEV*TW-1:0] dev_wr_tim
);

  // R2: window opens only right after the key write
  a_r2_open_after_key: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cfg_open) |-> $past(host_wr && !host_word && host_addr == 3'd2 && host_wdata[7:0] == 8'h03));

  // R8: close key shuts the window at the next edge
  a_r8_close_key: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_open && host_wr && !host_word && host_addr == 3'd2 && host_wdata[7:0] == 8'h83) |=> !cfg_open);

  // R4: no drive traffic and zero read data while open
  a_r4_open_isolated: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_open |-> (!drv_wr && !drv_rd && (!host_rd || host_rdata == '0)));

  // R4: timings only move through the open window or a strap change
  a_r4_locked_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cfg_open) && $stable(strap_clk)) |-> ($stable(dev_rd_tim) && $stable(dev_wr_tim)));

  // R9: probe read right after the arming write returns the strap
  a_r9_probe_read: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_open && host_rd && host_word && host_addr == 3'd5 &&
     $past(!cfg_open && host_wr && !host_word && host_addr == 3'd5 && host_wdata[7:0] == 8'hFF))
    |-> (host_rdata == DW'(strap_clk) && !drv_rd));

endmodule

bind ide_cfg_trapdoor ide_cfg_trapdoor_chk #(
  .NUM_DEV (NUM_DEV),
  .TW      (TW),
  .DW      (DW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_addr  (host_addr),
  .host_rd    (host_rd),
  .host_wr    (host_wr),
  .host_word  (host_word),
  .host_wdata (host_wdata),
  .host_rdata (host_rdata),
  .drv_rd     (drv_rd),
  .drv_wr     (drv_wr),
  .cfg_open   (cfg_open),
  .strap_clk  (strap_clk),
  .dev_rd_tim (dev_rd_tim),
  .dev_wr_tim (dev_wr_tim)
);

// File: tb/sim_ide_cfg_trapdoor.sv
`timescale 1ns/1ps
module sim_ide_cfg_trapdoor;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  host_addr;
  logic        host_rd, host_wr, host_word;
  logic [15:0] host_wdata, host_rdata;
  logic [2:0]  drv_addr;
  logic        drv_rd, drv_wr, drv_word;
  logic [15:0] drv_wdata, drv_rdata;
  logic        clk_strap;
  logic        cfg_open, timing_override, strap_clk;
  logic [0:0]  dev_sel;
  logic [3:0]  addr_setup;
  logic [15:0] dev_rd_tim, dev_wr_tim;

  int n_chk = 0;
  int n_bad = 0;

  logic        o_drd, o_dwr;
  logic [15:0] o_rdata, o_dwdata;

  always #5 clk = ~clk;

  // drive model: read data tags the offset
  assign drv_rdata = {8'hBE, 5'b0, drv_addr};

  ide_cfg_trapdoor u0 (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_rd(host_rd),
    .host_wr(host_wr), .host_word(host_word), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .drv_addr(drv_addr), .drv_rd(drv_rd),
    .drv_wr(drv_wr), .drv_word(drv_word), .drv_wdata(drv_wdata),
    .drv_rdata(drv_rdata), .clk_strap(clk_strap), .cfg_open(cfg_open),
    .timing_override(timing_override), .strap_clk(strap_clk),
    .dev_sel(dev_sel), .addr_setup(addr_setup),
    .dev_rd_tim(dev_rd_tim), .dev_wr_tim(dev_wr_tim)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one-cycle host access; forwarding and read data sampled mid-cycle
  task automatic acc(input logic wr, input logic word, input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    host_addr = a; host_word = word; host_wdata = d;
    host_wr = wr; host_rd = ~wr;
    #1;
    o_drd = drv_rd; o_dwr = drv_wr; o_rdata = host_rdata; o_dwdata = drv_wdata;
    @(posedge clk);
    #1;
    host_rd = 1'b0; host_wr = 1'b0;
  endtask

  task automatic settle();
    @(negedge clk);
  endtask

  task automatic unlock();
    acc(0, 1, 3'd1, 16'h0);
    acc(0, 1, 3'd1, 16'h0);
    acc(1, 0, 3'd2, 16'h0003);
  endtask

  task automatic t_reset();
    settle();
    check("R1 open", cfg_open, 0);
    check("R1 override", timing_override, 0);
    check("R1 rd tim", dev_rd_tim, 16'h6B6B);
    check("R1 wr tim", dev_wr_tim, 16'h6B6B);
    check("R1 setup", addr_setup, 4'h3);
  endtask

  task automatic t_unlock();
    acc(0, 1, 3'd1, 16'h0);
    check("R2 read1 fwd", o_drd, 1);
    check("R10 read data", o_rdata, 16'hBE01);
    acc(0, 1, 3'd1, 16'h0);
    check("R2 read2 fwd", o_drd, 1);
    acc(1, 0, 3'd2, 16'h0003);
    check("R2 key write fwd", o_dwr, 1);
    settle();
    check("R2 open", cfg_open, 1);
  endtask

  task automatic t_program();
    acc(1, 0, 3'd6, 16'h0000);
    check("R4 write absorbed", o_dwr, 0);
    acc(1, 0, 3'd0, 16'h0032);
    acc(1, 0, 3'd1, 16'h0031);
    acc(1, 0, 3'd6, 16'h0001);
    acc(1, 0, 3'd0, 16'h0022);
    acc(1, 0, 3'd1, 16'h0021);
    acc(1, 0, 3'd6, 16'h0010);
    settle();
    check("R6 sel kept", dev_sel, 1);
    check("R7 not yet", timing_override, 0);
    acc(1, 1, 3'd0, 16'hFFFF);
    acc(0, 1, 3'd0, 16'h0);
    check("R4 read zero", o_rdata, 16'h0000);
    check("R4 read absorbed", o_drd, 0);
    acc(1, 0, 3'd2, 16'h0055);
    acc(1, 0, 3'd3, 16'h0085);
    settle();
    check("R8 stays open", cfg_open, 1);
    check("R7 override on", timing_override, 1);
    check("R5 rd tim", dev_rd_tim, 16'h2232);
    check("R5 wr tim", dev_wr_tim, 16'h2131);
    check("R6 setup", addr_setup, 4'h1);
  endtask

  task automatic t_relock();
    acc(1, 0, 3'd2, 16'h0083);
    check("R8 close absorbed", o_dwr, 0);
    settle();
    check("R8 closed", cfg_open, 0);
    acc(1, 0, 3'd0, 16'h0077);
    check("R8 fwd after close", o_dwr, 1);
    check("R10 wdata pass", o_dwdata, 16'h0077);
    settle();
    check("R8 tim untouched", dev_rd_tim, 16'h2232);
  endtask

  task automatic t_broken();
    acc(0, 1, 3'd1, 16'h0);
    acc(0, 0, 3'd1, 16'h0);
    acc(0, 1, 3'd1, 16'h0);
    acc(1, 0, 3'd2, 16'h0003);
    settle();
    check("R3 byte read breaks", cfg_open, 0);
    acc(0, 1, 3'd1, 16'h0);
    acc(0, 1, 3'd1, 16'h0);
    acc(1, 0, 3'd2, 16'h0004);
    acc(1, 0, 3'd2, 16'h0003);
    settle();
    check("R3 wrong key breaks", cfg_open, 0);
    acc(0, 1, 3'd1, 16'h0);
    acc(0, 1, 3'd7, 16'h0);
    acc(0, 1, 3'd1, 16'h0);
    acc(1, 0, 3'd2, 16'h0003);
    settle();
    check("R3 other offset breaks", cfg_open, 0);
    acc(0, 1, 3'd1, 16'h0);
    acc(0, 1, 3'd1, 16'h0);
    acc(0, 1, 3'd1, 16'h0);
    acc(1, 0, 3'd2, 16'h0003);
    settle();
    check("R2 extra read ok", cfg_open, 1);
    acc(1, 0, 3'd2, 16'h0083);
  endtask

  task automatic t_override_off();
    unlock();
    acc(1, 0, 3'd3, 16'h0000);
    acc(1, 0, 3'd2, 16'h0083);
    settle();
    check("R7 override off", timing_override, 0);
    check("R7 default slow", dev_wr_tim, 16'h6B6B);
    clk_strap = 1'b1;
    settle(); settle();
    check("R1 default fast", dev_rd_tim, 16'h5858);
    check("R1 setup fast", addr_setup, 4'h2);
  endtask

  task automatic t_probe();
    acc(1, 0, 3'd5, 16'h00FF);
    check("R9 arm write fwd", o_dwr, 1);
    acc(0, 1, 3'd5, 16'h0);
    check("R9 strap data", o_rdata, 16'h0001);
    check("R9 not fwd", o_drd, 0);
    acc(0, 1, 3'd5, 16'h0);
    check("R10 disarmed read", o_rdata, 16'hBE05);
    clk_strap = 1'b0;
    acc(1, 0, 3'd5, 16'h00FF);
    acc(0, 1, 3'd5, 16'h0);
    check("R9 strap zero", o_rdata, 16'h0000);
    acc(1, 0, 3'd5, 16'h00FF);
    acc(0, 1, 3'd4, 16'h0);
    acc(0, 1, 3'd5, 16'h0);
    check("R9 disarm by access", o_drd, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; host_addr = '0; host_rd = 0; host_wr = 0; host_word = 0;
    host_wdata = '0; clk_strap = 1'b0;
    o_drd = 0; o_dwr = 0; o_rdata = '0; o_dwdata = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    t_reset();
    t_unlock();
    t_program();
    t_relock();
    t_broken();
    t_override_off();
    t_probe();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule